// File: doc/BRIEF.md
# Flexible Hard-Decision Traceback Unit

This block holds the survivor decisions of a trellis decoder and turns them into decoded bits. Every trellis step the add-compare-select stage hands it one column holding a decision bit for each state. Columns fill one of two banks. While that bank fills, the other bank, holding the previous frame, is walked backwards from a starting state. At each step the previous state is derived from the current state, the stored decision bit and the constraint length K. Any K from 3 to 9 is handled by the same equation.

In Viterbi mode the decoded bit follows directly from the current state. In Turbo mode it is looked up in a one-bit-wide table that a host loads beforehand. The table is indexed by twice the current state plus the decision bit. The walk yields bits last step first. They are parked in a reversal register and then streamed out first step first, with a valid strobe.

A frame is 128 steps. The constraint length, the mode and the starting-state choice travel with each frame. They are sampled together with its final column.

Top module: `tbk_traceback`

## Requirements
- R1: After reset `out_valid` stays low, and stays low until a complete frame has been written.
- R2: From current state C with decision bit d, the previous state is 2C+d-2^(K-1) when C >= 2^(K-2), and 2C+d otherwise. The decision bit for state C at a step is bit C of the column written for that step.
- R3: In Viterbi mode (`frame_turbo`=0) the decoded bit of a step is 1 exactly when that step's current state is at least 2^(K-2).
- R4: In Turbo mode the decoded bit is the table entry at address 2C+d. The table has 2^9 one-bit entries, written through `tbl_we`/`tbl_addr`/`tbl_bit`.
- R5: The walk starts at the state after the last step. That state is 0 when `start_best`=0, and `best_state` masked to K-1 bits when `start_best`=1, both sampled with the frame's 128th column.
- R6: `frame_k` (3 to 9) and `frame_turbo` are sampled with the 128th column and apply to that frame only.
- R7: Each frame yields 128 bits on consecutive cycles with `out_valid` high. The first bit belongs to the first column written.
- R8: A new frame may be written while the previous one is traced back, without disturbing either.
- R9: Banks swap only once the new frame is fully written and the previous frame has been fully output. Frames come out in the order they were written.
- R10: Columns presented while one frame waits complete and the other bank is still busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decision column is presented |
| dec_col | input | 256 | Decision bit per state, bit i for state i |
| frame_k | input | 4 | Constraint length of the frame, 3 to 9 |
| frame_turbo | input | 1 | 1 = Turbo table output, 0 = Viterbi rule |
| start_best | input | 1 | 1 = start from `best_state`, 0 = from state 0 |
| best_state | input | 8 | Best-metric state at the frame end |
| tbl_we | input | 1 | Decision table write enable |
| tbl_addr | input | 9 | Decision table write address |
| tbl_bit | input | 1 | Decision table write data |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded bit, natural time order |

## Verification
Writing a new frame's columns into one bank and reading the older frame's columns from the other bank happen in the same cycles. The bench provokes this by streaming a second frame while the first is still being traced. It then pushes extra columns while both banks are occupied, and starts a third frame as soon as the first has been emitted. Each frame's output is compared with a bench model of the backward walk. Any cross-bank write, lost column or early swap shows up as a mismatched bit stream.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
    parameter int KMAX  = 9;
    parameter int FRAME = 128;
    localparam int SW = KMAX - 1;
    localparam int NS = 1 << SW;
    localparam int AW = $clog2(FRAME);
    localparam int KW = 4;
    localparam int TD = 1 << KMAX;

    typedef enum logic [1:0] {PH_IDLE, PH_TRACE, PH_EMIT} phase_t;
endpackage

// File: rtl/tbk_bank_mem.sv
module tbk_bank_mem
    import tbk_pkg::*;
(
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [NS-1:0] wcol,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [NS-1:0] rcol
);
    localparam int DEPTH = 2 * FRAME;

    logic [NS-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[{wbank, waddr}] <= wcol;
    end

    assign rcol = mem_q[{rbank, raddr}];
endmodule

// File: rtl/tbk_step.sv
module tbk_step
    import tbk_pkg::*;
(
    input  logic [SW-1:0]   cur,
    input  logic            dec,
    input  logic [KW-1:0]   k,
    output logic [SW-1:0]   prev,
    output logic            vbit,
    output logic [KMAX-1:0] taddr
);
    logic [SW:0] twice;
    logic [SW:0] half;
    logic [SW:0] full;

    always_comb begin
        twice = {cur, dec};
        half  = (SW+1)'(1) << (k - KW'(2));
        full  = (SW+1)'(1) << (k - KW'(1));
        vbit  = ({1'b0, cur} >= half);
        prev  = vbit ? SW'(twice - full) : SW'(twice);
        taddr = twice;
    end
endmodule

// File: rtl/tbk_table.sv
module tbk_table
    import tbk_pkg::*;
(
    input  logic            clk,
    input  logic            we,
    input  logic [KMAX-1:0] waddr,
    input  logic            wbit,
    input  logic [KMAX-1:0] raddr,
    output logic            rbit
);
    logic [TD-1:0] tbl_q;

    always_ff @(posedge clk) begin
        if (we) tbl_q[waddr] <= wbit;
    end

    assign rbit = tbl_q[raddr];
endmodule

// File: rtl/tbk_traceback.sv
module tbk_traceback
    import tbk_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [NS-1:0]   dec_col,
    input  logic [KW-1:0]   frame_k,
    input  logic            frame_turbo,
    input  logic            start_best,
    input  logic [SW-1:0]   best_state,
    input  logic            tbl_we,
    input  logic [KMAX-1:0] tbl_addr,
    input  logic            tbl_bit,
    output logic            out_valid,
    output logic            out_bit
);
    typedef struct packed {
        phase_t         phase;
        logic           wr_bank;
        logic [AW-1:0]  wptr;
        logic           wdone;
        logic [KW-1:0]  pend_k;
        logic           pend_turbo;
        logic [SW-1:0]  pend_start;
        logic [KW-1:0]  act_k;
        logic           act_turbo;
        logic [SW-1:0]  cur;
        logic [AW-1:0]  tptr;
        logic [FRAME-1:0] rev;
        logic           ovalid;
        logic           obit;
    } tb_state_t;

    tb_state_t q, d;

    logic            wr_en;
    logic [NS-1:0]   rd_col;
    logic            dec_bit;
    logic [SW-1:0]   prev_state;
    logic            viterbi_bit;
    logic [KMAX-1:0] table_addr;
    logic            table_bit;
    logic [SW-1:0]   start_mask;

    assign wr_en = dec_valid && !q.wdone;

    tbk_bank_mem u_mem (
        .clk   (clk),
        .we    (wr_en),
        .wbank (q.wr_bank),
        .waddr (q.wptr),
        .wcol  (dec_col),
        .rbank (~q.wr_bank),
        .raddr (q.tptr),
        .rcol  (rd_col)
    );

    assign dec_bit = rd_col[q.cur];

    tbk_step u_step (
        .cur   (q.cur),
        .dec   (dec_bit),
        .k     (q.act_k),
        .prev  (prev_state),
        .vbit  (viterbi_bit),
        .taddr (table_addr)
    );

    tbk_table u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wbit  (tbl_bit),
        .raddr (table_addr),
        .rbit  (table_bit)
    );

    always_comb begin
        d = q;
        d.ovalid = 1'b0;
        start_mask = (SW'(1) << (frame_k - KW'(1))) - SW'(1);

        // column write side
        if (wr_en) begin
            if (q.wptr == AW'(FRAME - 1)) begin
                d.wptr       = '0;
                d.wdone      = 1'b1;
                d.pend_k     = frame_k;
                d.pend_turbo = frame_turbo;
                d.pend_start = start_best ? (best_state & start_mask) : '0;
            end else begin
                d.wptr = q.wptr + AW'(1);
            end
        end

        // traceback and emit side
        unique case (q.phase)
            PH_IDLE: begin
                if (q.wdone) begin
                    d.wr_bank   = ~q.wr_bank;
                    d.wdone     = 1'b0;
                    d.act_k     = q.pend_k;
                    d.act_turbo = q.pend_turbo;
                    d.cur       = q.pend_start;
                    d.tptr      = AW'(FRAME - 1);
                    d.phase     = PH_TRACE;
                end
            end
            PH_TRACE: begin
                d.rev[q.tptr] = q.act_turbo ? table_bit : viterbi_bit;
                d.cur = prev_state;
                if (q.tptr == '0) begin
                    d.phase = PH_EMIT;
                end else begin
                    d.tptr = q.tptr - AW'(1);
                end
            end
            PH_EMIT: begin
                d.ovalid = 1'b1;
                d.obit   = q.rev[q.tptr];
                if (q.tptr == AW'(FRAME - 1)) begin
                    d.phase = PH_IDLE;
                end else begin
                    d.tptr = q.tptr + AW'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ovalid;
    assign out_bit   = q.obit;
endmodule

// File: rtl/tbk_checker.sv
module tbk_checker
    import tbk_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input phase_t        phase,
    input logic          wr_bank,
    input logic          wdone,
    input logic [SW-1:0] cur,
    input logic [SW-1:0] pend_start,
    input logic [KW-1:0] act_k,
    input logic          out_valid
);
    logic [SW:0] full_lim;
    assign full_lim = (SW+1)'(1) << (act_k - KW'(1));

    // R2: the walked state never leaves the K-1 bit state space
    p_state_in_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRACE) |-> ({1'b0, cur} < full_lim));

    // R5: the walk begins at the start state captured with the frame
    p_start_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRACE && $past(phase) == PH_IDLE) |-> (cur == $past(pend_start)));

    // R7: output strobe only follows an emit cycle
    p_strobe_from_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(phase) == PH_EMIT));

    // R9: banks swap only with a complete frame and an idle reader
    p_swap_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bank != $past(wr_bank)) |-> ($past(wdone) && $past(phase) == PH_IDLE));

    // R10: a waiting frame keeps its captured start while held
    p_pending_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wdone && $past(wdone)) |-> $stable(pend_start));
endmodule

bind tbk_traceback tbk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (q.phase),
    .wr_bank    (q.wr_bank),
    .wdone      (q.wdone),
    .cur        (q.cur),
    .pend_start (q.pend_start),
    .act_k      (q.act_k),
    .out_valid  (out_valid)
);

// File: tb/sim_tbk_traceback.sv
module sim_tbk_traceback;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dec_valid = 1'b0;
    logic [255:0] dec_col = '0;
    logic [3:0]   frame_k = 4'd3;
    logic         frame_turbo = 1'b0;
    logic         start_best = 1'b0;
    logic [7:0]   best_state = '0;
    logic         tbl_we = 1'b0;
    logic [8:0]   tbl_addr = '0;
    logic         tbl_bit = 1'b0;
    logic         out_valid;
    logic         out_bit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [255:0] cols [4][128];
    logic         lut_m [512];
    int           fk [4];
    bit           ft [4];
    int           fs [4];

    always #10 clk = ~clk;

    tbk_traceback u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_col(dec_col),
        .frame_k(frame_k), .frame_turbo(frame_turbo), .start_best(start_best),
        .best_state(best_state), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_bit(tbl_bit), .out_valid(out_valid), .out_bit(out_bit)
    );

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, got no end, expected completion");
            report();
            $finish;
        end
    end

    function automatic logic [127:0] model(int f);
        logic [127:0] e;
        int c = fs[f];
        for (int t = 127; t >= 0; t--) begin
            int dd = cols[f][t][c];
            int half = 1 << (fk[f] - 2);
            int two = 2 * c + dd;
            bit v = (c >= half);
            e[t] = ft[f] ? lut_m[two] : v;
            c = v ? two - (1 << (fk[f] - 1)) : two;
        end
        return e;
    endfunction

    task automatic gen(int f, int k, bit turbo, int start, int kind);
        fk[f] = k; ft[f] = turbo; fs[f] = start;
        for (int t = 0; t < 128; t++) begin
            if (kind == 1) cols[f][t] = '0;
            else if (kind == 2) cols[f][t] = '1;
            else cols[f][t] = {$urandom, $urandom, $urandom, $urandom,
                               $urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic write_frame(int f, bit best_sel, int best);
        for (int t = 0; t < 128; t++) begin
            @(negedge clk);
            dec_valid   = 1'b1;
            dec_col     = cols[f][t];
            frame_k     = 4'(fk[f]);
            frame_turbo = ft[f];
            start_best  = best_sel;
            best_state  = 8'(best);
        end
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic push_garbage(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dec_valid   = 1'b1;
            dec_col     = {8{$urandom}};
            frame_k     = 4'd9;
            frame_turbo = 1'b1;
            start_best  = 1'b1;
            best_state  = 8'hFF;
        end
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic collect_check(int f, string tag);
        logic [127:0] got;
        logic [127:0] exp;
        bit contig = 1;
        while (!out_valid) @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            got[i] = out_bit;
            if (!out_valid) contig = 0;
            @(negedge clk);
        end
        exp = model(f);
        checks++;
        if (!contig) begin
            fails++;
            $display("FAIL R7 frame %0d: valid burst broken, got gap, expected 128 consecutive", f);
        end
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s frame %0d: got %h expected %h", tag, f, got, exp);
        end
    endtask

    // R1: quiet output after reset and before any full frame
    task automatic t_reset;
        bit seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (out_valid !== 1'b0) seen = 1;
        end
        checks++;
        if (seen) begin
            fails++;
            $display("FAIL R1: got out_valid high after reset, expected 0");
        end
        gen(0, 3, 0, 0, 0);
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            dec_valid = 1'b1;
            dec_col = cols[0][t];
            frame_k = 4'd3;
            frame_turbo = 1'b0;
            start_best = 1'b0;
            if (out_valid !== 1'b0) seen = 1;
        end
        @(negedge clk);
        dec_valid = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (out_valid !== 1'b0) seen = 1;
        end
        checks++;
        if (seen) begin
            fails++;
            $display("FAIL R1: got output on partial frame, expected none");
        end
        // finish that frame with the remaining 28 columns
        for (int t = 100; t < 128; t++) begin
            @(negedge clk);
            dec_valid = 1'b1;
            dec_col = cols[0][t];
        end
        @(negedge clk);
        dec_valid = 1'b0;
        collect_check(0, "R2 R3 R6 K=3 split write");
    endtask

    // R2 R3 R5: Viterbi, K=9, best start
    task automatic t_viterbi_k9;
        gen(1, 9, 0, 200, 0);
        write_frame(1, 1, 200);
        collect_check(1, "R2 R3 R5 K=9 best start");
    endtask

    // R4 R5 R6: Turbo table lookup, K=4, best start masked
    task automatic t_turbo;
        for (int a = 0; a < 512; a++) begin
            lut_m[a] = 1'($urandom);
            @(negedge clk);
            tbl_we = 1'b1;
            tbl_addr = 9'(a);
            tbl_bit = lut_m[a];
        end
        @(negedge clk);
        tbl_we = 1'b0;
        gen(2, 4, 1, 5, 0);
        write_frame(2, 1, 8'hFD); // masked to 3 bits gives 5
        collect_check(2, "R4 R5 R6 turbo K=4");
    endtask

    // R2 R3: all-ones and all-zero decision boundaries
    task automatic t_bounds;
        logic [127:0] e;
        gen(3, 3, 0, 3, 2);
        e = model(3);
        checks++;
        if (e !== '1) begin
            fails++;
            $display("FAIL R3 model: got %h expected all ones", e);
        end
        write_frame(3, 1, 3);
        collect_check(3, "R2 R3 all-ones K=3");
        gen(3, 7, 0, 0, 1);
        write_frame(3, 0, 0);
        collect_check(3, "R2 R3 all-zero K=7");
    endtask

    // R8 R9 R10: write during traceback, extra columns, back-to-back
    task automatic t_overlap;
        gen(0, 7, 0, 0, 0);
        gen(1, 5, 1, 11, 0);
        gen(2, 9, 1, 0, 0);
        write_frame(0, 0, 0);
        fork
            collect_check(0, "R8 R9 frame A");
            begin
                write_frame(1, 1, 11);
                push_garbage(20);
            end
        join
        fork
            write_frame(2, 0, 0);
            collect_check(1, "R8 R9 R10 frame B");
        join
        collect_check(2, "R8 R10 frame C");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_viterbi_k9();
        t_turbo();
        t_bounds();
        t_overlap();
        done = 1;
        report();
        $finish;
    end
endmodule